// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Pins

An eight-bit storage register with four operations: keep its contents, shift toward the high end, shift toward the low end, or capture a parallel word. Parallel data leaves and enters on one set of bidirectional pins. In synthesis each pin is split into an input value, an output value and an output enable. A wrapper at the chip edge can fold these three signals into an inout.

The register drives the pins only when both active-low enables are low and the block is not in load mode. In load mode the pins are released so that another source can drive the word to be captured. The enables only gate the pin drivers; the register keeps shifting, loading and resetting while the pins float. The end bits are copied to two serial outputs that are never released, so registers can be chained.

Top module: `bidir_shift_reg`

## Requirements
- R1: An active-low reset `rstN` clears all register bits to 0 immediately, with no clock edge needed, whatever the mode select.
- R2: With `modeSel` = 2'b00 (hold), a rising clock edge leaves the register unchanged.
- R3: With `modeSel` = 2'b01 (shift right), each rising edge moves bit n-1 into bit n and puts `serInRight` into bit 0.
- R4: With `modeSel` = 2'b10 (shift left), each rising edge moves bit n+1 into bit n and puts `serInLeft` into bit 7.
- R5: With `modeSel` = 2'b11 (load), a rising edge copies `padIn` into the register.
- R6: `padOut` always shows the register. All bits of `padOe` are 1 when `oeN1` and `oeN2` are both 0 and the mode is not load.
- R7: If `oeN1` or `oeN2` is 1, all bits of `padOe` are 0.
- R8: In load mode all bits of `padOe` are 0, whatever the enables are.
- R9: Hold, shift, load and reset work the same while the pins are released by the enables.
- R10: `serOutLow` shows bit 0 and `serOutHigh` shows bit 7 at all times, whatever the enables and the mode are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register changes on the rising edge |
| rstN | input | 1 | Asynchronous clear, active low |
| modeSel | input | 2 | Operation select: 00 hold, 01 right, 10 left, 11 load |
| serInRight | input | 1 | New bit 0 on a right shift |
| serInLeft | input | 1 | New bit 7 on a left shift |
| oeN1 | input | 1 | Pin driver enable, active low |
| oeN2 | input | 1 | Pin driver enable, active low |
| padIn | input | 8 | Value sampled from the parallel pins |
| padOut | output | 8 | Value driven onto the parallel pins |
| padOe | output | 8 | Per-pin driver enable |
| serOutLow | output | 1 | Bit 0, always driven |
| serOutHigh | output | 1 | Bit 7, always driven |

## Verification
The hardest case to reach is a change to the register while the pins are released. The parallel outputs cannot show that change, so it has to be seen another way. The bench shifts with one enable high and watches the end bits on the serial outputs. It then drops the enables, in hold mode, and reads the full word back on the pins. Every one of the 256 byte values is loaded through the released pins and then shifted in both directions with both serial input values, and the enable pattern is taken from the data itself.

// File: rtl/bidir_shift_pkg.sv
package bidir_shift_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } shiftMode_e;

  typedef struct packed {
    logic shiftRight;
    logic shiftLeft;
    logic load;
    logic padDrive;
  } ctrlStrobes_t;
endpackage

// File: rtl/bidir_shift_ctrl.sv
module bidir_shift_ctrl
  import bidir_shift_pkg::*;
(
  input  logic [1:0]   modeSel,
  input  logic         oeN1,
  input  logic         oeN2,
  output ctrlStrobes_t strobes
);
  shiftMode_e mode;
  logic pinsReleased;

  assign mode = shiftMode_e'(modeSel);

  always_comb begin
    strobes = '0;
    pinsReleased = oeN1 | oeN2;
    case (mode)
      MODE_RIGHT: strobes.shiftRight = 1'b1;
      MODE_LEFT:  strobes.shiftLeft  = 1'b1;
      MODE_LOAD: begin
        strobes.load = 1'b1;
        pinsReleased = 1'b1;
      end
      default: ;
    endcase
    strobes.padDrive = ~pinsReleased;
  end

  // R8: load mode never drives the shared pins
  always_comb begin
    assert_load_release_R8: assert (!(modeSel == 2'b11 && strobes.padDrive));
  end

  // at most one register operation strobe at a time
  always_comb begin
    assert_one_op_R2: assert ($onehot0({strobes.shiftRight, strobes.shiftLeft, strobes.load}));
  end
endmodule

// File: rtl/bidir_shift_datapath.sv
module bidir_shift_datapath
  import bidir_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] dIn,
  input  logic             serInRight,
  input  logic             serInLeft,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = WIDTH - 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   q <= '0;
    else if (strobes.load)       q <= dIn;
    else if (strobes.shiftRight) q <= {q[TOP-1:0], serInRight};
    else if (strobes.shiftLeft)  q <= {serInLeft, q[TOP:1]};
  end

  always @(posedge clk) begin
    if (!rstN) assert_reset_clear_R1: assert (q == '0);
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load || strobes.shiftRight || strobes.shiftLeft) |=> $stable(q));

  assert_shift_right_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shiftRight && !strobes.load) |=> (q[0] == $past(serInRight)) && (q[TOP:1] == $past(q[TOP-1:0])));

  assert_shift_left_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shiftLeft && !strobes.load) |=> (q[TOP] == $past(serInLeft)) && (q[TOP-1:0] == $past(q[TOP:1])));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> q == $past(dIn));
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bidir_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             serInRight,
  input  logic             serInLeft,
  input  logic             oeN1,
  input  logic             oeN2,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic             serOutLow,
  output logic             serOutHigh
);
  ctrlStrobes_t strobes;
  logic [WIDTH-1:0] regQ;

  bidir_shift_ctrl u_ctrl (
    .modeSel (modeSel),
    .oeN1    (oeN1),
    .oeN2    (oeN2),
    .strobes (strobes)
  );

  bidir_shift_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .dIn        (padIn),
    .serInRight (serInRight),
    .serInLeft  (serInLeft),
    .q          (regQ)
  );

  assign padOut     = regQ;
  assign padOe      = {WIDTH{strobes.padDrive}};
  assign serOutLow  = regQ[0];
  assign serOutHigh = regQ[WIDTH-1];

  assert_enable_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (oeN1 || oeN2) |-> padOe == '0);

  assert_serial_ends_R10: assert property (@(posedge clk) disable iff (!rstN)
    {serOutHigh, serOutLow} == {padOut[WIDTH-1], padOut[0]});
endmodule

// File: tb/bidir_shift_reg_tb.sv
module bidir_shift_reg_tb;
  logic clk = 1'b0;
  logic rstN;
  logic [1:0] modeSel;
  logic serInRight, serInLeft, oeN1, oeN2;
  logic [7:0] padIn, padOut, padOe;
  logic serOutLow, serOutHigh;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] model;

  always #4 clk = ~clk;

  bidir_shift_reg u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .serInRight(serInRight),
    .serInLeft(serInLeft), .oeN1(oeN1), .oeN2(oeN2), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .serOutLow(serOutLow), .serOutHigh(serOutHigh)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // drive at negedge, edge, then sample 1 ns after the edge
  task automatic step(input logic [1:0] m, input logic sr, input logic sl, input logic [7:0] d);
    @(negedge clk);
    modeSel = m; serInRight = sr; serInLeft = sl; padIn = d;
    @(posedge clk);
    case (m)
      2'b01: model = {model[6:0], sr};
      2'b10: model = {sl, model[7:1]};
      2'b11: model = d;
      default: ;
    endcase
    #1;
  endtask

  task automatic check_ends(input string req);
    chk(req, {30'd0, serOutHigh, serOutLow}, {30'd0, model[7], model[0]});
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rstN = 1'b0; modeSel = 2'b11; serInRight = 1'b0; serInLeft = 1'b0;
    oeN1 = 1'b0; oeN2 = 1'b0; padIn = 8'hA5; model = 8'h00;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset state", {24'd0, padOut}, 32'h0);
    check_ends("R10 reset ends");
    chk("R8 pins released in load during reset", {24'd0, padOe}, 32'h0);
    @(negedge clk); rstN = 1'b1; modeSel = 2'b00;
    #1;
    chk("R6 pins driven in hold", {24'd0, padOe}, 32'hFF);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      oeN1 = 1'b0; oeN2 = 1'b0;
      // R5/R8: load through the released pins
      @(negedge clk); modeSel = 2'b11; #1;
      chk("R8 load releases pins", {24'd0, padOe}, 32'h0);
      step(2'b11, 1'b0, 1'b0, b);
      step(2'b00, 1'b0, 1'b0, ~b);
      chk("R5 load captures pins", {24'd0, padOut}, {24'd0, model});
      chk("R6 pins driven after load", {24'd0, padOe}, 32'hFF);
      chk("R2 hold keeps value", {24'd0, padOut}, {24'd0, b});
      // R9/R7: shift with pins released, watch serial ends
      oeN1 = b[1]; oeN2 = b[2];
      step(2'b01, b[0], ~b[0], 8'h00);
      check_ends("R3 R9 R10 right shift ends");
      if (b[1] | b[2]) chk("R7 enable releases pins", {24'd0, padOe}, 32'h0);
      else chk("R6 enables low drive pins", {24'd0, padOe}, 32'hFF);
      step(2'b10, b[3], ~b[3], 8'h00);
      check_ends("R4 R9 R10 left shift ends");
      step(2'b10, ~b[4], b[4], 8'h00);
      step(2'b01, b[5], b[6], 8'h00);
      step(2'b00, 1'b1, 1'b1, 8'hFF);
      oeN1 = 1'b0; oeN2 = 1'b0; #1;
      chk("R3 R4 R9 word after shifts", {24'd0, padOut}, {24'd0, model});
      step(2'b01, b[7], 1'b0, 8'h00);
      chk("R3 right shift word", {24'd0, padOut}, {24'd0, model});
      step(2'b10, 1'b0, b[7], 8'h00);
      chk("R4 left shift word", {24'd0, padOut}, {24'd0, model});
    end

    // R1 asynchronous: reset mid-cycle with pins released and load selected
    oeN1 = 1'b1;
    step(2'b11, 1'b0, 1'b0, 8'hC3);
    @(negedge clk); #1; rstN = 1'b0; #1;
    model = 8'h00;
    check_ends("R1 R9 async clear with pins released");
    @(negedge clk); rstN = 1'b1; modeSel = 2'b00; oeN1 = 1'b0; #1;
    chk("R1 word after async clear", {24'd0, padOut}, 32'h0);
    oeN2 = 1'b1; #1;
    chk("R7 second enable releases pins", {24'd0, padOe}, 32'h0);
    finish_run();
  end
endmodule